// File: doc/BRIEF.md
# Write Status Byte Generator

This block forms the byte a host reads back from a nonvolatile memory while an internal program or erase runs. The command decoder pulses `op_start_i` when the last write cycle of a program sequence (the fourth) or an erase sequence (the sixth) completes. With that pulse come the operation kind and bit 7 of the byte being programmed. From the next cycle on, the block replaces array data with a status byte. Bit 7 is a polling bit whose meaning depends on the operation kind. Bit 6 flips on every read access. An external operation timer drives `busy_i` and keeps it high for as long as the internal operation runs.

When `busy_i` falls, the block enters a settle window that lasts `SETTLE_CYCLES` clocks. In this window bit 7 already shows its final value, bit 6 is frozen and the lower bits stay masked. This models the interval in which the rest of the byte is not yet valid. After the window, array data passes through unchanged. Tri-stating the bus and the array itself belong to other blocks.

The sequencer has four states. `ST_PASS` passes array data through. `ST_PROG` is a program in progress and `ST_ERASE` is an erase in progress. `ST_SETTLE` is the window after completion. The transitions are:
- `ST_PASS`→`ST_PROG` or `ST_PASS`→`ST_ERASE` on an accepted start, chosen by `op_erase_i`.
- `ST_PROG` or `ST_ERASE`→`ST_SETTLE` when `busy_i` is low.
- `ST_SETTLE`→`ST_PASS` when the window count runs out.
- `ST_SETTLE`→`ST_PROG` or `ST_SETTLE`→`ST_ERASE` on a new start.

Top module: `wr_status_gen`

## Requirements
- R1: While reset is asserted and after it is released, the block is in `ST_PASS`, and `status_o` equals `array_data_i` in the same cycle.
- R2: In `ST_PROG`, bit 7 of `status_o` is the inverse of the `prog_msb_i` value captured in the cycle when the start was accepted.
- R3: In `ST_ERASE`, bit 7 of `status_o` is 0. During the settle window that follows an erase, bit 7 is 1.
- R4: In `ST_PROG` or `ST_ERASE`, each clock with `rd_strobe_i` high inverts bit 6 of `status_o` from the next cycle on. In a cycle without a strobe, bit 6 holds its value.
- R5: Bits 5 down to 0 of `status_o` read 0 in `ST_PROG`, `ST_ERASE` and `ST_SETTLE`, whatever `array_data_i` holds.
- R6: A clock edge that finds `ST_PROG` or `ST_ERASE` with `busy_i` low starts a settle window of exactly `SETTLE_CYCLES` cycles. In the window, bit 7 is the true value (the captured bit for a program, 1 for an erase) and bit 6 is frozen even under read strobes. After the window, `status_o` equals `array_data_i`.
- R7: `op_start_i` is accepted in `ST_PASS` and in `ST_SETTLE`, and the block is busy from the next cycle on. In `ST_PROG` and `ST_ERASE` it is ignored: the operation kind, the captured bit and bit 6 do not change.
- R8: An accepted start clears the bit 6 toggle, so the first busy cycle shows bit 6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start_i | input | 1 | One-cycle pulse: internal operation begins |
| op_erase_i | input | 1 | Operation kind with the start: 1 = erase, 0 = program |
| prog_msb_i | input | 1 | Bit 7 of the byte being programmed |
| busy_i | input | 1 | High while the operation timer runs |
| rd_strobe_i | input | 1 | One clock per host read access |
| array_data_i | input | DATA_W | Byte read from the array |
| status_o | output | DATA_W | Byte returned to the host |

## Verification
In every cycle, the assertions check the polling bit against the operation kind and the captured bit, and the masking of the low bits while busy or settling. They also check that bit 6 flips after a strobe in a busy state and stays frozen in the settle window, that the toggle is cleared by a start, that the settle count stays in range, and that a second start during a program is refused. Only the bench scenarios can show the following: the exact length of the settle window, the return to array data at its end, and that a refused start leaves the captured bit and the toggle phase intact. The bench shows these by comparing every cycle against a behavioural model over back-to-back program and erase runs, with strobes in consecutive and spaced cycles.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    typedef enum logic [1:0] {
        ST_PASS   = 2'd0,
        ST_PROG   = 2'd1,
        ST_ERASE  = 2'd2,
        ST_SETTLE = 2'd3
    } wsg_state_e;

    function automatic logic wsg_is_busy(input wsg_state_e st);
        return (st == ST_PROG) || (st == ST_ERASE);
    endfunction

endpackage

// File: rtl/wsg_seq.sv
module wsg_seq
    import wsg_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start_i,
    input  logic       op_erase_i,
    input  logic       prog_msb_i,
    input  logic       busy_i,
    output wsg_state_e state_o,
    output logic       launch_o,
    output logic       cap_msb_o,
    output logic       cap_erase_o
);

    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SETTLE_CYCLES - 1);

    wsg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             launch;
    logic             msb_q, erase_q;

    // state register and settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and launch decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        launch  = 1'b0;
        unique case (state_q)
            ST_PASS: begin
                if (op_start_i) begin
                    launch  = 1'b1;
                    state_d = op_erase_i ? ST_ERASE : ST_PROG;
                end
            end
            ST_PROG, ST_ERASE: begin
                if (!busy_i) begin
                    state_d = ST_SETTLE;
                    cnt_d   = CNT_TOP;
                end
            end
            ST_SETTLE: begin
                if (op_start_i) begin
                    launch  = 1'b1;
                    state_d = op_erase_i ? ST_ERASE : ST_PROG;
                end else if (cnt_q == '0) begin
                    state_d = ST_PASS;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // operation attributes captured at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q   <= 1'b0;
            erase_q <= 1'b0;
        end else if (launch) begin
            msb_q   <= prog_msb_i;
            erase_q <= op_erase_i;
        end
    end

    assign state_o     = state_q;
    assign launch_o    = launch;
    assign cap_msb_o   = msb_q;
    assign cap_erase_o = erase_q;

    // R6: window counter never exceeds its loaded value
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> (cnt_q <= CNT_TOP));

    // R6: expired window without a new start returns to pass-through
    a_r6_settle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && cnt_q == '0 && !op_start_i) |=> (state_q == ST_PASS));

    // R7: a start during a running program is refused
    a_r7_hold_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && busy_i && op_start_i) |=> (state_q == ST_PROG && $stable(msb_q)));

    // R7: a start during a running erase is refused
    a_r7_hold_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && busy_i && op_start_i) |=> (state_q == ST_ERASE));

endmodule

// File: rtl/wsg_toggle.sv
module wsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic advance_i,
    output logic tog_o
);

    logic tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (clear_i) begin
            tog_q <= 1'b0;
        end else if (advance_i) begin
            tog_q <= ~tog_q;
        end
    end

    assign tog_o = tog_q;

endmodule

// File: rtl/wsg_drive.sv
module wsg_drive
    import wsg_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  wsg_state_e        state_i,
    input  logic              cap_msb_i,
    input  logic              cap_erase_i,
    input  logic              tog_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] status_o
);

    localparam int unsigned POLL_BIT = DATA_W - 1;
    localparam int unsigned TOG_BIT  = DATA_W - 2;

    always_comb begin
        status_o = '0;
        unique case (state_i)
            ST_PASS: begin
                status_o = array_data_i;
            end
            ST_PROG: begin
                status_o[POLL_BIT] = ~cap_msb_i;
                status_o[TOG_BIT]  = tog_i;
            end
            ST_ERASE: begin
                status_o[POLL_BIT] = 1'b0;
                status_o[TOG_BIT]  = tog_i;
            end
            ST_SETTLE: begin
                status_o[POLL_BIT] = cap_erase_i ? 1'b1 : cap_msb_i;
                status_o[TOG_BIT]  = tog_i;
            end
        endcase
    end

endmodule

// File: rtl/wr_status_gen.sv
module wr_status_gen
    import wsg_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start_i,
    input  logic              op_erase_i,
    input  logic              prog_msb_i,
    input  logic              busy_i,
    input  logic              rd_strobe_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] status_o
);

    localparam int unsigned POLL_BIT = DATA_W - 1;
    localparam int unsigned TOG_BIT  = DATA_W - 2;
    localparam int unsigned LOW_W    = DATA_W - 2;

    wsg_state_e state;
    logic       launch;
    logic       cap_msb;
    logic       cap_erase;
    logic       tog;
    logic       in_busy;

    assign in_busy = wsg_is_busy(state);

    wsg_seq #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start_i (op_start_i),
        .op_erase_i (op_erase_i),
        .prog_msb_i (prog_msb_i),
        .busy_i     (busy_i),
        .state_o    (state),
        .launch_o   (launch),
        .cap_msb_o  (cap_msb),
        .cap_erase_o(cap_erase)
    );

    wsg_toggle u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (launch),
        .advance_i(rd_strobe_i && in_busy),
        .tog_o    (tog)
    );

    wsg_drive #(
        .DATA_W(DATA_W)
    ) u_drive (
        .state_i     (state),
        .cap_msb_i   (cap_msb),
        .cap_erase_i (cap_erase),
        .tog_i       (tog),
        .array_data_i(array_data_i),
        .status_o    (status_o)
    );

    // R1: pass-through immediately after reset
    a_r1_reset_pass: assert property (@(posedge clk)
        !rst_n |=> (state == ST_PASS));

    // R2: program polling bit is the inverse of the captured bit
    a_r2_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |-> (status_o[POLL_BIT] == !cap_msb));

    // R3: erase polling bit reads low while erasing
    a_r3_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) |-> (status_o[POLL_BIT] == 1'b0));

    // R4: a strobe while busy flips bit 6 if still busy next cycle
    a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (in_busy && rd_strobe_i) |=> (!in_busy || (status_o[TOG_BIT] != $past(status_o[TOG_BIT]))));

    // R5: low bits masked whenever status is shown
    a_r5_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PASS) |-> (status_o[LOW_W-1:0] == '0));

    // R6: bit 6 frozen inside the settle window
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && !op_start_i) |=> (state != ST_SETTLE || $stable(status_o[TOG_BIT])));

    // R8: toggle restarts at zero on a launch
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (status_o[TOG_BIT] == 1'b0));

endmodule

// File: tb/wr_status_gen_test.sv
module wr_status_gen_test;

    localparam int SETTLE = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start_i = 1'b0;
    logic       op_erase_i = 1'b0;
    logic       prog_msb_i = 1'b0;
    logic       busy_i = 1'b0;
    logic       rd_strobe_i = 1'b0;
    logic [7:0] array_data_i = 8'h00;
    logic [7:0] status_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model: phase 0 pass, 1 busy, 2 settle
    int m_phase = 0;
    int m_erase = 0;
    int m_bit   = 0;
    int m_tog   = 0;
    int m_left  = 0;

    always #5 clk = ~clk;

    wr_status_gen #(.DATA_W(8), .SETTLE_CYCLES(SETTLE)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_start_i  (op_start_i),
        .op_erase_i  (op_erase_i),
        .prog_msb_i  (prog_msb_i),
        .busy_i      (busy_i),
        .rd_strobe_i (rd_strobe_i),
        .array_data_i(array_data_i),
        .status_o    (status_o)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: status actual=%02h expected=%02h at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic cyc();
        @(negedge clk);
        #2;
    endtask

    // model update at each edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_tog = 0; m_left = 0;
        end else if (m_phase == 1) begin
            if (rd_strobe_i) m_tog = 1 - m_tog;
            if (!busy_i) begin m_phase = 2; m_left = SETTLE - 1; end
        end else if (op_start_i) begin
            m_phase = 1; m_erase = op_erase_i; m_bit = prog_msb_i; m_tog = 0;
        end else if (m_phase == 2) begin
            if (m_left == 0) m_phase = 0;
            else m_left--;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        logic [7:0] e;
        string      tag;
        #1;
        if (m_phase == 0) begin
            e = array_data_i; tag = "R1 pass";
        end else if (m_phase == 1) begin
            e = 8'h00;
            e[7] = m_erase ? 1'b0 : !m_bit[0];
            e[6] = m_tog[0];
            tag = m_erase ? "R3 erase busy" : "R2 program busy";
        end else begin
            e = 8'h00;
            e[7] = m_erase ? 1'b1 : m_bit[0];
            e[6] = m_tog[0];
            tag = "R6 settle";
        end
        check(status_o, e, tag);
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        array_data_i = 8'h3C;
        cyc(); cyc();
        check(status_o, 8'h3C, "R1 in reset");
        rst_n = 1'b1;
        cyc();
        check(status_o, 8'h3C, "R1 after reset");

        // program, bit 7 = 1, low bits masked
        array_data_i = 8'h3F;
        op_start_i = 1; op_erase_i = 0; prog_msb_i = 1; busy_i = 1;
        cyc(); op_start_i = 0; prog_msb_i = 0;
        check(status_o, 8'h00, "R2 R8 R5 first busy read");
        rd_strobe_i = 1;
        cyc(); rd_strobe_i = 0;
        check(status_o, 8'h40, "R4 flip after read");
        cyc();
        check(status_o, 8'h40, "R4 hold without read");
        rd_strobe_i = 1;
        cyc(); rd_strobe_i = 0; busy_i = 0;
        check(status_o, 8'h00, "R4 second flip");
        cyc();
        array_data_i = 8'hA5;
        check(status_o, 8'h80, "R6 program settle true bit");
        rd_strobe_i = 1;
        for (int i = 1; i < SETTLE; i++) begin
            cyc();
            check(status_o, 8'h80, "R6 frozen in window");
        end
        rd_strobe_i = 0;
        cyc();
        check(status_o, 8'hA5, "R6 pass after window");

        // erase with consecutive reads
        array_data_i = 8'hFF;
        op_start_i = 1; op_erase_i = 1; prog_msb_i = 1; busy_i = 1;
        cyc(); op_start_i = 0;
        check(status_o, 8'h00, "R3 R5 erase busy");
        rd_strobe_i = 1;
        cyc(); check(status_o, 8'h40, "R4 consecutive 1");
        cyc(); check(status_o, 8'h00, "R4 consecutive 2");
        cyc(); check(status_o, 8'h40, "R4 consecutive 3");
        rd_strobe_i = 0; busy_i = 0;
        cyc(); check(status_o, 8'hC0, "R3 erase done bit 7 high");

        // start accepted during settle
        op_start_i = 1; op_erase_i = 0; prog_msb_i = 0; busy_i = 1;
        cyc(); op_start_i = 0;
        check(status_o, 8'h80, "R7 R8 start in settle");

        // start refused while busy
        op_start_i = 1; op_erase_i = 1; prog_msb_i = 1; rd_strobe_i = 1;
        cyc(); op_start_i = 0; rd_strobe_i = 0;
        check(status_o, 8'hC0, "R7 start ignored while busy");
        busy_i = 0;
        cyc(); check(status_o, 8'h40, "R7 R6 program true bit 0");
        for (int i = 1; i < SETTLE; i++) cyc();
        array_data_i = 8'h5A;
        cyc();
        check(status_o, 8'h5A, "R6 pass after second window");

        cyc(); cyc();
        finish_run();
    end

endmodule